// File: doc/BRIEF.md
# SPI Serial Clock Generator with Two Divide Laws

This block turns a fast module clock into the serial clock of an SPI master. It also produces one-cycle strobes that mark each leading and each trailing serial-clock edge, so a shifter can launch and capture data on the right edges. A transfer engine holds `run_en` high for the length of a burst. While `run_en` is low the serial clock rests at the level given on `cpol`.

The divide ratio comes from a small control word that has two divide laws. A law-select bit picks which field is used. When the bit is clear, a 4-bit exponent n gives a serial clock of f/2^(n+1), which covers f/2 down to f/65536. When the bit is set, an 8-bit value n gives an even divide, f/(2*(n+1)), which covers f/2 down to f/512 in fine steps. The field that is not selected has no effect.

The control word is only written while the engine is idle, so a burst can never produce a shortened clock pulse. The half-period counter restarts at each enable, so the first half-period of every burst is full length.

Top module: `spi_clkdiv`

## Requirements
- R1: While `rst` is high at a clock edge, `sclk`, `lead_stb` and `trail_stb` are all 0 after that edge.
- R2: While `run_en` is sampled low, `sclk` takes the value of `cpol` sampled at the same edge, and neither strobe is asserted.
- R3: With `cfg_law_lin`=0 (power-of-two law) and exponent n, the serial-clock half-period is 2^n module-clock cycles.
- R4: With `cfg_law_lin`=1 (linear law) and value n, the serial-clock half-period is n+1 module-clock cycles.
- R5: Only the field picked by `cfg_law_lin` sets the divide. The other field has no effect on timing.
- R6: The first `sclk` transition of a burst follows the H-th rising edge at which `run_en` is sampled high, where H is the half-period. Later transitions follow every H further edges.
- R7: `lead_stb` is high for exactly the cycle in which `sclk` has just left the idle level. `trail_stb` is high for exactly the cycle in which `sclk` has just returned to it. The two strobes are never high together, and `sclk` never changes while `run_en` stays high unless one of them is asserted.
- R8: A write (`cfg_we`=1) is accepted only at an edge where `run_en` is sampled low, and it governs the next burst. A write made while `run_en` is high is discarded.
- R9: When `run_en` is sampled low, `sclk` returns to the idle level after that edge even in the middle of a half-period. The next burst again starts with a full half-period.
- R10: The range limits hold: exponent 0 toggles `sclk` on every edge, exponent 15 gives a half-period of 32768 cycles, and linear value 255 gives a half-period of 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Burst enable from the transfer engine |
| cpol | input | 1 | Idle level of the serial clock |
| cfg_we | input | 1 | Write strobe for the divider control word |
| cfg_law_lin | input | 1 | Law select: 0 power-of-two, 1 linear |
| cfg_pow_exp | input | 4 | Power-of-two exponent n |
| cfg_lin_div | input | 8 | Linear divide value n |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse when sclk leaves idle |
| trail_stb | output | 1 | One-cycle pulse when sclk returns to idle |

## Verification
Let c0 be the cycle in which `run_en` is raised. The k-th serial-clock edge and its strobe are due exactly H·k module-clock edges later, because the counter and the edge register each add one register stage and the strobe shares the edge register with `sclk`. For every burst, the driver pushes each edge's due cycle, its kind and the expected `sclk` level into a queue. The monitor samples on the falling clock, so each strobe and level is read half a cycle after the edge that produced it; it fails any strobe that is early, unexpected or missing. The idle level and reset values are due one edge after the stimulus and are sampled at the next falling clock.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    localparam int POW_W  = 4;
    localparam int LIN_W  = 8;
    localparam int POW_MAX_EXP = (1 << POW_W) - 1;
    localparam int TERM_W = (POW_MAX_EXP > LIN_W) ? POW_MAX_EXP : LIN_W;

    typedef enum logic {
        LAW_POW = 1'b0,
        LAW_LIN = 1'b1
    } law_e;

    typedef struct packed {
        law_e             law;
        logic [POW_W-1:0] pow_exp;
        logic [LIN_W-1:0] lin_div;
    } cfg_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } strobe_t;

    // terminal count = half-period minus one
    function automatic logic [TERM_W-1:0] term_of(input cfg_t c);
        logic [TERM_W-1:0] t;
        if (c.law == LAW_LIN)
            t = TERM_W'(c.lin_div);
        else
            t = TERM_W'((32'd1 << c.pow_exp) - 32'd1);
        return t;
    endfunction

endpackage

// File: rtl/spi_clkdiv_cfg.sv
module spi_clkdiv_cfg
    import spi_clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              cfg_we,
    input  cfg_t              cfg_in,
    output logic [TERM_W-1:0] term_o
);
    logic [TERM_W-1:0] term_q;

    // writes land only while the engine is idle
    always_ff @(posedge clk) begin
        if (rst)
            term_q <= '0;
        else if (cfg_we && !run_en)
            term_q <= term_of(cfg_in);
    end

    assign term_o = term_q;
endmodule

// File: rtl/spi_clkdiv_cnt.sv
module spi_clkdiv_cnt
    import spi_clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [TERM_W-1:0] term,
    output logic              tick
);
    logic [TERM_W-1:0] cnt_q;

    assign tick = run_en && (cnt_q == term);

    always_ff @(posedge clk) begin
        if (rst || !run_en)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_clkdiv_edge.sv
module spi_clkdiv_edge
    import spi_clkdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run_en,
    input  logic    cpol,
    input  logic    tick,
    output logic    sclk,
    output strobe_t stb
);
    logic    pol_q;
    logic    phase_q;
    strobe_t stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q   <= 1'b0;
            phase_q <= 1'b0;
            stb_q   <= '0;
        end else if (!run_en) begin
            pol_q   <= cpol;
            phase_q <= 1'b0;
            stb_q   <= '0;
        end else if (tick) begin
            phase_q     <= ~phase_q;
            stb_q.lead  <= ~phase_q;
            stb_q.trail <= phase_q;
        end else begin
            stb_q <= '0;
        end
    end

    assign sclk = pol_q ^ phase_q;
    assign stb  = stb_q;
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
    import spi_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             cpol,
    input  logic             cfg_we,
    input  logic             cfg_law_lin,
    input  logic [POW_W-1:0] cfg_pow_exp,
    input  logic [LIN_W-1:0] cfg_lin_div,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    cfg_t              cfg_in;
    logic [TERM_W-1:0] term;
    logic              tick;
    strobe_t           stb;

    always_comb begin
        cfg_in.law     = law_e'(cfg_law_lin);
        cfg_in.pow_exp = cfg_pow_exp;
        cfg_in.lin_div = cfg_lin_div;
    end

    spi_clkdiv_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cfg_we (cfg_we),
        .cfg_in (cfg_in),
        .term_o (term)
    );

    spi_clkdiv_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .term   (term),
        .tick   (tick)
    );

    spi_clkdiv_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cpol   (cpol),
        .tick   (tick),
        .sclk   (sclk),
        .stb    (stb)
    );

    assign lead_stb  = stb.lead;
    assign trail_stb = stb.trail;
endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic cpol,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (sclk == $past(cpol))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!lead_stb && !trail_stb)); // R2

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lead_stb && trail_stb)); // R7

    AST_STB_MARKS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (lead_stb || trail_stb) |-> (sclk != $past(sclk))); // R7

    AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lead_stb |=> !lead_stb); // R7

    AST_EDGE_HAS_STB: assert property (@(posedge clk) disable iff (rst)
        ((sclk != $past(sclk)) && $past(run_en)) |-> (lead_stb || trail_stb)); // R7
endmodule

bind spi_clkdiv spi_clkdiv_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/spi_clkdiv_tb_top.sv
module spi_clkdiv_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic       cpol = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_law_lin = 1'b0;
    logic [3:0] cfg_pow_exp = 4'd0;
    logic [7:0] cfg_lin_div = 8'd0;
    logic       sclk, lead_stb, trail_stb;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    longint cyc     = 0;

    typedef struct {
        longint due;
        bit     lead;
        bit     lvl;
        string  tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_clkdiv dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .cpol(cpol),
        .cfg_we(cfg_we), .cfg_law_lin(cfg_law_lin),
        .cfg_pow_exp(cfg_pow_exp), .cfg_lin_div(cfg_lin_div),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: compare strobes against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (lead_stb || trail_stb) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected strobe at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, e.tag, "edge cycle", cyc, e.due);
                    chk(lead_stb == e.lead && trail_stb == !e.lead, e.tag,
                        "strobe kind lead", lead_stb, e.lead);
                    chk(sclk == e.lvl, e.tag, "sclk level", sclk, e.lvl);
                end
            end else if (q.size() > 0 && q[0].due < cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(1'b0, e.tag, "missed edge due at", cyc, e.due);
            end
        end
    end

    task automatic set_cfg(input bit law, input logic [3:0] ex, input logic [7:0] dv);
        @(negedge clk);
        cfg_law_lin = law;
        cfg_pow_exp = ex;
        cfg_lin_div = dv;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: run a burst of n edges with half-period h, drop enable extra cycles later
    task automatic burst(input int h, input int n, input int extra, input string tag);
        longint c0;
        @(negedge clk);
        c0 = cyc;
        run_en = 1'b1;
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.due  = c0 + longint'(k) * h;
            e.lead = (k % 2) == 1;
            e.lvl  = cpol ^ ((k % 2) == 1);
            e.tag  = tag;
            q.push_back(e);
        end
        while (cyc != c0 + longint'(n) * h + extra) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        // R9: back to idle one edge after enable drops
        chk(sclk == cpol, "R9", "sclk idle after drop", sclk, cpol);
        chk(q.size() == 0, tag, "pending edges after burst", q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(!lead_stb && !trail_stb, "R1", "strobes in reset", lead_stb | trail_stb, 0);
        rst = 1'b0;

        // R2: idle level follows cpol
        @(negedge clk); cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R2", "idle level high", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R2", "idle level low", sclk, 0);

        // R3 / R6: power-of-two, exponent 2 -> half 4, linear field junk
        set_cfg(1'b0, 4'd2, 8'h55);
        burst(4, 6, 0, "R3");

        // R5: linear selected, exponent junk -> half 5
        @(negedge clk); cpol = 1'b1;
        set_cfg(1'b1, 4'd9, 8'd4);
        burst(5, 5, 0, "R5");

        // R4: linear value 2 -> half 3
        set_cfg(1'b1, 4'd0, 8'd2);
        burst(3, 4, 0, "R4");

        // R10: exponent 0 toggles every edge
        @(negedge clk); cpol = 1'b0;
        set_cfg(1'b0, 4'd0, 8'd200);
        burst(1, 8, 0, "R10");

        // R8: write during burst ignored
        set_cfg(1'b0, 4'd1, 8'd0);
        fork
            burst(2, 10, 0, "R8");
            begin
                repeat (3) @(negedge clk);
                cfg_law_lin = 1'b1; cfg_lin_div = 8'd9; cfg_we = 1'b1;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        burst(2, 4, 0, "R8");
        set_cfg(1'b1, 4'd0, 8'd9);
        burst(10, 3, 0, "R8");

        // R9: abort mid half-period, then full first half-period
        set_cfg(1'b0, 4'd3, 8'd0);
        burst(8, 2, 5, "R9");
        burst(8, 3, 0, "R6");

        // R10: range limits
        set_cfg(1'b1, 4'd0, 8'd255);
        burst(256, 3, 0, "R10");
        set_cfg(1'b0, 4'd15, 8'd0);
        burst(32768, 2, 0, "R10");

        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end
endmodule